// File: doc/BRIEF.md
# Receive Automatic Gain Control Loop

This block scales a stream of complex receive samples by a running gain and keeps that gain moving toward a target level. I and Q samples share one data input and are qualified by a valid flag. Each accepted sample is multiplied by a total gain, which is a programmed 24-bit base gain plus a signed adjustment held in an accumulator. The adjustment then takes one shift-sized step up or down. The size and direction of the step depend on where the scaled sample lands: below or above a magnitude threshold, or inside a run of zero or clipped outputs. In dual mode two channels keep separate adjustments and separate base gains.

The scaled product is rounded to a programmable width and saturated symmetrically. A freeze control, ORed with an external hold input for time-division duplex operation, stops the loop and passes the full unrounded product. A clear control empties the accumulators. A monitor mode replaces the low part of each output word with gain and loop-state bits.

Top module: `rx_agc`

## Requirements
- R1: A result appears with dout_valid high exactly one cycle after each cycle in which din_valid is high. A cycle without din_valid changes neither the adjustment, the run counts nor the sample slot, and dout_valid is low in the cycle that follows it.
- R2: Accepted samples alternate I then Q, and dout_iq reports the slot (0 = I, 1 = Q). With dual_mode low every sample belongs to channel 0 and uses base_gain_a. With dual_mode high the order is I and Q of channel 0, then I and Q of channel 1, and channel 1 uses base_gain_b and its own adjustment. dout_ch reports the channel.
- R3: The total gain is base gain plus adjustment, clamped to the range 0 to 2^24-1. The scaled product is y = floor(x * gain / 2^15), a 25-bit signed value, where x is the signed 16-bit sample.
- R4: Let m = min(255, floor(|y| / 2^16)). If m < thresh, the adjustment rises by 2^(21-step_blw); otherwise it falls by 2^(21-step_abv). A 4-bit step code c therefore means a shift of c+3 applied against the 24-bit gain scale.
- R5: With zero_mask high, the lowest 4 bits of din are treated as zero before the multiplication.
- R6: Each channel counts its consecutive zero rounded outputs and its consecutive clipped rounded outputs. Each count saturates at 15 and restarts at 0 on a sample that breaks its condition. A sample that is zero and is at least the zero_cnt-th zero in a row raises the adjustment by 2^(21-step_zro). A sample that clipped and is at least the sat_cnt-th clip in a row lowers it by 2^(21-step_sat). The clip run takes precedence over the zero run, and both take precedence over the threshold rule.
- R7: After each step the adjustment is limited to the range adj_min*2^8 to adj_max*2^8. Both limits are signed 16-bit values with 12 integer and 4 fraction bits. The upper limit is applied before the lower limit.
- R8: While freeze or hold_in is high, the adjustment does not change.
- R9: A clock edge with clear high sets the adjustments of both channels to zero. This overrides a step and also works while frozen.
- R10: Rounding code r selects an output width of 18-r bits. The rounded value is t = floor((y + 2^(6+r)) / 2^(7+r)); the 2^(6+r) offset is left out when rnd_off is high. t is saturated symmetrically to +/-(2^(17-r)-1) and placed on dout sign-extended to 25 bits. A sample that needs this saturation counts as clipped.
- R11: While freeze or hold_in is high and gain_mon is low, dout carries the unrounded y.
- R12: With gain_mon high, dout[24:18] is zero. For an I sample, dout[17:0] = {d8, gain[23:16], 2'b00}. For a Q sample, dout[17:0] = {d8, gain[15:10], state, 2'b00}. Here d8 is the low 8 bits of the R10 result computed with r = 10, gain is the total gain used for that sample, and state is 0 below threshold, 1 above threshold, 2 zero run, 3 clip run. gain_mon takes precedence over R11.
- R13: After reset, dout is 0, dout_valid, dout_iq and dout_ch are 0, all adjustments and run counts are 0, and the next sample is the I sample of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Signed sample, I and Q interleaved |
| din_valid | input | 1 | Sample qualifier |
| dual_mode | input | 1 | Two channels with separate gains |
| zero_mask | input | 1 | Clear the 4 low sample bits |
| rnd_code | input | 4 | Output width select (18 minus code) |
| rnd_off | input | 1 | Truncate instead of round |
| thresh | input | 8 | Magnitude threshold |
| step_blw | input | 4 | Step code below threshold |
| step_abv | input | 4 | Step code at or above threshold |
| step_zro | input | 4 | Step code for a zero run |
| step_sat | input | 4 | Step code for a clip run |
| zero_cnt | input | 4 | Zero run length that selects step_zro |
| sat_cnt | input | 4 | Clip run length that selects step_sat |
| adj_max | input | 16 | Upper adjustment limit, signed 12.4 |
| adj_min | input | 16 | Lower adjustment limit, signed 12.4 |
| base_gain_a | input | 24 | Base gain of channel 0 |
| base_gain_b | input | 24 | Base gain of channel 1 |
| freeze | input | 1 | Hold the loop |
| hold_in | input | 1 | External hold, ORed with freeze |
| clear | input | 1 | Zero the adjustments |
| gain_mon | input | 1 | Pack gain and state into outputs |
| dout | output | 25 | Result word |
| dout_valid | output | 1 | Result qualifier |
| dout_iq | output | 1 | Result slot, 0 = I, 1 = Q |
| dout_ch | output | 1 | Result channel |

## Verification
The bench sweeps all sixteen rounding codes with rounding on and off, using samples near full scale. A wrong offset or an asymmetric clip shows up there as a one-count error or as a wrapped sign. It drives zero runs with the mask on and then off, and clip runs at high gain. A design that counts runs across channels, or that fails to restart a run, picks the wrong step, and the next output is then scaled by the wrong gain. It forces the adjustment against tight and inverted-scale limits, and against steps of 2^21. A clamp that is missing or applied in the wrong order lets the gain drift past the limits. It also checks that freeze, the hold input and clear leave exactly the base gain in effect. Finally it compares the packed monitor words bit by bit in both channel modes, where a swapped field or a gain sampled after the update shows up at once.

// File: rtl/rx_agc_pkg.sv
package rx_agc_pkg;
  localparam int SMP_W    = 16;
  localparam int GAIN_W   = 24;
  localparam int PROD_W   = GAIN_W + 1;
  localparam int ADJ_W    = GAIN_W + 1;
  localparam int WIDE_W   = PROD_W + 2;
  localparam int OUT_W    = 18;
  localparam int LIM_W    = 16;
  localparam int LIM_SH   = 8;
  localparam int NCH      = 2;
  localparam int CH_W     = $clog2(NCH);
  localparam int FRAC     = SMP_W - 1;
  localparam int MAG_SH   = PROD_W - 9;
  localparam int RND_BASE = PROD_W - OUT_W;
  localparam int MON_CODE = OUT_W - 8;
  localparam int STEP_TOP = GAIN_W - 3;

  typedef enum logic [1:0] {
    STP_BLW = 2'd0,
    STP_ABV = 2'd1,
    STP_ZRO = 2'd2,
    STP_SAT = 2'd3
  } step_e;

  typedef struct packed {
    logic signed [PROD_W-1:0] val;
    logic                     ovf;
  } rnd_t;

  function automatic logic [GAIN_W-1:0] total_gain(input logic [GAIN_W-1:0] base,
                                                   input logic signed [ADJ_W-1:0] adj);
    logic signed [WIDE_W-1:0] s;
    logic signed [WIDE_W-1:0] top;
    top = $signed({{(WIDE_W-GAIN_W){1'b0}}, {GAIN_W{1'b1}}});
    s = $signed({{(WIDE_W-GAIN_W){1'b0}}, base}) + $signed({{(WIDE_W-ADJ_W){adj[ADJ_W-1]}}, adj});
    if (s < 0) return '0;
    if (s > top) return '1;
    return s[GAIN_W-1:0];
  endfunction

  function automatic logic signed [PROD_W-1:0] scale(input logic signed [SMP_W-1:0] d,
                                                     input logic [GAIN_W-1:0] g);
    logic signed [SMP_W+GAIN_W:0] p;
    p = $signed({{(GAIN_W+1){d[SMP_W-1]}}, d}) * $signed({{SMP_W{1'b0}}, 1'b0, g});
    return p[FRAC+PROD_W-1:FRAC];
  endfunction

  function automatic logic [7:0] mag8(input logic signed [PROD_W-1:0] y);
    logic [PROD_W-1:0] a;
    a = y[PROD_W-1] ? -y : y;
    if (a[PROD_W-1]) return 8'hFF;
    return a[MAG_SH+7:MAG_SH];
  endfunction

  function automatic rnd_t round_sat(input logic signed [PROD_W-1:0] y,
                                     input logic [3:0] code, input logic dis);
    rnd_t r;
    logic signed [WIDE_W-1:0] t, half, lim, nlim;
    int sh;
    sh = RND_BASE + int'(code);
    half = '0;
    if (!dis) half[sh-1] = 1'b1;
    lim = '0;
    lim[OUT_W-1-int'(code)] = 1'b1;
    lim = lim - 1;
    nlim = -lim;
    t = ($signed({{(WIDE_W-PROD_W){y[PROD_W-1]}}, y}) + half) >>> sh;
    r.ovf = (t > lim) || (t < nlim);
    if (t > lim) r.val = lim[PROD_W-1:0];
    else if (t < nlim) r.val = nlim[PROD_W-1:0];
    else r.val = t[PROD_W-1:0];
    return r;
  endfunction

  function automatic logic signed [ADJ_W-1:0] step_delta(input logic [3:0] code);
    logic signed [ADJ_W-1:0] d;
    d = '0;
    d[STEP_TOP-int'(code)] = 1'b1;
    return d;
  endfunction
endpackage

// File: rtl/rx_agc_dp.sv
module rx_agc_dp
  import rx_agc_pkg::*;
(
  input  logic signed [SMP_W-1:0]  din,
  input  logic                     zero_mask,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [3:0]               rnd_code,
  input  logic                     rnd_off,
  input  logic [7:0]               thresh,
  output logic signed [PROD_W-1:0] y,
  output rnd_t                     rv,
  output logic [7:0]               mon8,
  output logic                     below
);
  logic signed [SMP_W-1:0] d_m;
  rnd_t mon_r;

  always_comb begin
    d_m   = zero_mask ? {din[SMP_W-1:4], 4'h0} : din;
    y     = scale(d_m, gain);
    rv    = round_sat(y, rnd_code, rnd_off);
    mon_r = round_sat(y, 4'(MON_CODE), rnd_off);
    mon8  = mon_r.val[7:0];
    below = mag8(y) < thresh;
  end
endmodule

// File: rtl/rx_agc_chan.sv
module rx_agc_chan
  import rx_agc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    frz,
  input  logic                    clr,
  input  logic                    zero,
  input  logic                    ovf,
  input  logic                    below,
  input  logic [3:0]              step_blw,
  input  logic [3:0]              step_abv,
  input  logic [3:0]              step_zro,
  input  logic [3:0]              step_sat,
  input  logic [3:0]              zero_cnt,
  input  logic [3:0]              sat_cnt,
  input  logic signed [LIM_W-1:0] lim_hi,
  input  logic signed [LIM_W-1:0] lim_lo,
  output logic signed [ADJ_W-1:0] adj,
  output step_e                   mode
);
  logic [3:0] zrun, srun;
  logic zhit, shit;
  logic [3:0] code;
  logic signed [ADJ_W-1:0] delta, hi_w, lo_w;
  logic signed [WIDE_W-1:0] nxt;

  assign hi_w = $signed({{(ADJ_W-LIM_W-LIM_SH){lim_hi[LIM_W-1]}}, lim_hi, {LIM_SH{1'b0}}});
  assign lo_w = $signed({{(ADJ_W-LIM_W-LIM_SH){lim_lo[LIM_W-1]}}, lim_lo, {LIM_SH{1'b0}}});
  assign zhit = zero && (({1'b0, zrun} + 5'd1) >= {1'b0, zero_cnt});
  assign shit = ovf && (({1'b0, srun} + 5'd1) >= {1'b0, sat_cnt});

  always_comb begin
    if (shit)       mode = STP_SAT;
    else if (zhit)  mode = STP_ZRO;
    else if (below) mode = STP_BLW;
    else            mode = STP_ABV;
    case (mode)
      STP_BLW: code = step_blw;
      STP_ABV: code = step_abv;
      STP_ZRO: code = step_zro;
      default: code = step_sat;
    endcase
    delta = step_delta(code);
    if (mode == STP_BLW || mode == STP_ZRO)
      nxt = $signed({{2{adj[ADJ_W-1]}}, adj}) + $signed({{2{delta[ADJ_W-1]}}, delta});
    else
      nxt = $signed({{2{adj[ADJ_W-1]}}, adj}) - $signed({{2{delta[ADJ_W-1]}}, delta});
    if (nxt > $signed({{2{hi_w[ADJ_W-1]}}, hi_w})) nxt = $signed({{2{hi_w[ADJ_W-1]}}, hi_w});
    if (nxt < $signed({{2{lo_w[ADJ_W-1]}}, lo_w})) nxt = $signed({{2{lo_w[ADJ_W-1]}}, lo_w});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj  <= '0;
      zrun <= '0;
      srun <= '0;
    end else begin
      if (clr) adj <= '0;
      else if (upd && !frz) adj <= nxt[ADJ_W-1:0];
      if (upd) begin
        zrun <= zero ? ((zrun == 4'hF) ? zrun : zrun + 4'd1) : 4'd0;
        srun <= ovf  ? ((srun == 4'hF) ? srun : srun + 4'd1) : 4'd0;
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (adj == '0)); // R9
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !clr) |=> $stable(adj)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(adj)); // R1
  AST_ADJ_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !frz && !clr && (lo_w <= hi_w)) |=> ((adj <= $past(hi_w)) && (adj >= $past(lo_w)))); // R7
endmodule

// File: rtl/rx_agc.sv
module rx_agc
  import rx_agc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [SMP_W-1:0]  din,
  input  logic                     din_valid,
  input  logic                     dual_mode,
  input  logic                     zero_mask,
  input  logic [3:0]               rnd_code,
  input  logic                     rnd_off,
  input  logic [7:0]               thresh,
  input  logic [3:0]               step_blw,
  input  logic [3:0]               step_abv,
  input  logic [3:0]               step_zro,
  input  logic [3:0]               step_sat,
  input  logic [3:0]               zero_cnt,
  input  logic [3:0]               sat_cnt,
  input  logic signed [LIM_W-1:0]  adj_max,
  input  logic signed [LIM_W-1:0]  adj_min,
  input  logic [GAIN_W-1:0]        base_gain_a,
  input  logic [GAIN_W-1:0]        base_gain_b,
  input  logic                     freeze,
  input  logic                     hold_in,
  input  logic                     clear,
  input  logic                     gain_mon,
  output logic [PROD_W-1:0]        dout,
  output logic                     dout_valid,
  output logic                     dout_iq,
  output logic [CH_W-1:0]          dout_ch
);
  logic [1:0]              ph;
  logic                    is_q;
  logic [CH_W-1:0]         ch;
  logic                    frz;
  logic [GAIN_W-1:0]       gain;
  logic signed [PROD_W-1:0] y_w;
  rnd_t                    rv;
  logic [7:0]              mon8;
  logic                    below;
  logic                    zero;
  logic signed [ADJ_W-1:0] adj_w [NCH];
  step_e                   mode_w [NCH];
  logic [OUT_W-1:0]        mon_word;
  logic [PROD_W-1:0]       out_nxt;

  assign is_q = ph[0];
  assign ch   = dual_mode ? CH_W'(ph[1]) : '0;
  assign frz  = freeze | hold_in;
  assign gain = total_gain((ch != '0) ? base_gain_b : base_gain_a, adj_w[ch]);
  assign zero = (rv.val == '0);

  rx_agc_dp u_dp (
    .din(din), .zero_mask(zero_mask), .gain(gain), .rnd_code(rnd_code),
    .rnd_off(rnd_off), .thresh(thresh), .y(y_w), .rv(rv), .mon8(mon8), .below(below)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rx_agc_chan u_chan (
      .clk(clk), .rst_n(rst_n), .upd(din_valid && (ch == CH_W'(c))),
      .frz(frz), .clr(clear), .zero(zero), .ovf(rv.ovf), .below(below),
      .step_blw(step_blw), .step_abv(step_abv), .step_zro(step_zro), .step_sat(step_sat),
      .zero_cnt(zero_cnt), .sat_cnt(sat_cnt), .lim_hi(adj_max), .lim_lo(adj_min),
      .adj(adj_w[c]), .mode(mode_w[c])
    );
  end

  always_comb begin
    if (is_q) mon_word = {mon8, gain[15:10], mode_w[ch], 2'b00};
    else      mon_word = {mon8, gain[23:16], 2'b00};
    if (gain_mon) out_nxt = {{(PROD_W-OUT_W){1'b0}}, mon_word};
    else if (frz) out_nxt = y_w;
    else          out_nxt = rv.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      dout_iq    <= 1'b0;
      dout_ch    <= '0;
    end else begin
      dout_valid <= din_valid;
      if (din_valid) begin
        dout    <= out_nxt;
        dout_iq <= is_q;
        dout_ch <= ch;
        ph      <= dual_mode ? ph + 2'd1 : {1'b0, ~ph[0]};
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |=> dout_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> !dout_valid); // R1
  AST_FRZ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && frz && !gain_mon) |=> (dout == $past(y_w))); // R11
  AST_IQ_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !dual_mode) |=> (dout_iq == $past(is_q))); // R2
endmodule

// File: tb/rx_agc_test.sv
module rx_agc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] din = '0;
  logic din_valid = 1'b0, dual_mode = 1'b0, zero_mask = 1'b0, rnd_off = 1'b0;
  logic [3:0] rnd_code = '0;
  logic [7:0] thresh = 8'd20;
  logic [3:0] step_blw = 4'd10, step_abv = 4'd10, step_zro = 4'd6, step_sat = 4'd6;
  logic [3:0] zero_cnt = 4'd3, sat_cnt = 4'd2;
  logic signed [15:0] adj_max = 16'sh7FFF, adj_min = -16'sh8000;
  logic [23:0] base_gain_a = 24'h400000, base_gain_b = 24'h100000;
  logic freeze = 1'b0, hold_in = 1'b0, clear = 1'b0, gain_mon = 1'b0;
  logic [24:0] dout;
  logic dout_valid, dout_iq;
  logic [0:0] dout_ch;

  int n_chk = 0, n_bad = 0;
  longint m_adj [2];
  int m_z [2], m_s [2];
  int m_ph;

  always #5 clk = ~clk;

  rx_agc uut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid), .dual_mode(dual_mode),
    .zero_mask(zero_mask), .rnd_code(rnd_code), .rnd_off(rnd_off), .thresh(thresh),
    .step_blw(step_blw), .step_abv(step_abv), .step_zro(step_zro), .step_sat(step_sat),
    .zero_cnt(zero_cnt), .sat_cnt(sat_cnt), .adj_max(adj_max), .adj_min(adj_min),
    .base_gain_a(base_gain_a), .base_gain_b(base_gain_b), .freeze(freeze),
    .hold_in(hold_in), .clear(clear), .gain_mon(gain_mon), .dout(dout),
    .dout_valid(dout_valid), .dout_iq(dout_iq), .dout_ch(dout_ch)
  );

  function automatic longint rmodel(input longint y, input int r, input bit dis, output bit ovf);
    longint t, lim;
    t = y + (dis ? 64'sd0 : (64'sd1 <<< (6 + r)));
    t = t >>> (7 + r);
    lim = (64'sd1 <<< (17 - r)) - 1;
    ovf = (t > lim) || (t < -lim);
    if (t > lim) t = lim;
    if (t < -lim) t = -lim;
    return t;
  endfunction

  task automatic idle_check(input string tag);
    @(negedge clk);
    n_chk++;
    if (dout_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: dout_valid=%b expected 0", tag, dout_valid);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    m_adj[0] = 0; m_adj[1] = 0;
  endtask

  task automatic send(input int sv, input string tag);
    logic signed [15:0] s;
    longint d, g, y, v, mv, delta, hi, lo;
    int ch, iq, mode, code, mag;
    bit ovf, ovm, zero, zh, sh;
    logic [17:0] w;
    logic [24:0] ex;
    bit hold;
    s = 16'(sv);
    hold = freeze || hold_in;
    ch = dual_mode ? ((m_ph >> 1) & 1) : 0;
    iq = m_ph & 1;
    g = longint'(ch != 0 ? base_gain_b : base_gain_a) + m_adj[ch];
    if (g < 0) g = 0;
    if (g > 64'sd16777215) g = 64'sd16777215;
    d = zero_mask ? longint'($signed({s[15:4], 4'h0})) : longint'(s);
    y = (d * g) >>> 15;
    mag = int'((y < 0 ? -y : y) / 65536);
    if (mag > 255) mag = 255;
    v  = rmodel(y, int'(rnd_code), rnd_off, ovf);
    mv = rmodel(y, 10, rnd_off, ovm);
    zero = (v == 0);
    zh = zero && (m_z[ch] + 1 >= int'(zero_cnt));
    sh = ovf && (m_s[ch] + 1 >= int'(sat_cnt));
    mode = sh ? 3 : zh ? 2 : (mag < int'(thresh)) ? 0 : 1;
    m_z[ch] = zero ? ((m_z[ch] < 15) ? m_z[ch] + 1 : 15) : 0;
    m_s[ch] = ovf ? ((m_s[ch] < 15) ? m_s[ch] + 1 : 15) : 0;
    if (!hold) begin
      code = (mode == 0) ? int'(step_blw) : (mode == 1) ? int'(step_abv) :
             (mode == 2) ? int'(step_zro) : int'(step_sat);
      delta = 64'sd1 <<< (21 - code);
      m_adj[ch] = (mode == 0 || mode == 2) ? m_adj[ch] + delta : m_adj[ch] - delta;
      hi = longint'(adj_max) * 256;
      lo = longint'(adj_min) * 256;
      if (m_adj[ch] > hi) m_adj[ch] = hi;
      if (m_adj[ch] < lo) m_adj[ch] = lo;
    end
    if (iq != 0) w = {mv[7:0], g[15:10], 2'(mode), 2'b00};
    else         w = {mv[7:0], g[23:16], 2'b00};
    ex = gain_mon ? {7'b0, w} : hold ? y[24:0] : v[24:0];
    m_ph = dual_mode ? (m_ph + 1) % 4 : ((m_ph ^ 1) & 1);
    @(negedge clk);
    din = s; din_valid = 1'b1;
    @(negedge clk);
    din_valid = 1'b0;
    n_chk++;
    if (dout !== ex || dout_iq !== iq[0] || dout_ch !== ch[0] || dout_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: dout=%h iq=%b ch=%b vld=%b expected dout=%h iq=%0d ch=%0d vld=1",
               tag, dout, dout_iq, dout_ch, dout_valid, ex, iq, ch);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_adj[0] = 0; m_adj[1] = 0; m_z[0] = 0; m_z[1] = 0; m_s[0] = 0; m_s[1] = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    // R13: reset state
    n_chk++;
    if (dout !== '0 || dout_valid !== 1'b0 || dout_iq !== 1'b0 || dout_ch !== 1'b0) begin
      n_bad++;
      $display("FAIL R13: dout=%h vld=%b expected 0 0", dout, dout_valid);
    end
    rst_n = 1'b1;
    // R3 R4: threshold loop over a spread of amplitudes, single channel
    for (int k = 0; k < 40; k++) send(((k * 7919) % 65536) - 32768, "R4");
    // R1: no valid, no output
    idle_check("R1"); idle_check("R1");
    // R10: every rounding code, rounding on and off
    for (int c = 0; c < 16; c++)
      for (int dis = 0; dis < 2; dis++) begin
        rnd_code = 4'(c); rnd_off = dis[0];
        for (int k = 0; k < 4; k++) send(((k * 4099 + c * 977 + dis * 31) % 65536) - 32768, "R10");
      end
    // R5 R6: zero runs with the low bits masked, then unmasked
    rnd_code = 4'd0; rnd_off = 1'b0;
    do_clear();
    zero_mask = 1'b1;
    for (int k = 1; k < 12; k++) send(k, "R6");
    zero_mask = 1'b0;
    for (int k = 1; k < 9; k++) send(k, "R5");
    // R6: clip runs at high gain
    do_clear();
    base_gain_a = 24'hFFFF00; rnd_code = 4'd5;
    for (int k = 0; k < 12; k++) send((k % 2 == 0) ? 30000 : -30000, "R6");
    // R7: tight limits with coarse then fine steps
    base_gain_a = 24'h400000; rnd_code = 4'd2;
    adj_max = 16'sd4; adj_min = -16'sd4;
    step_blw = 4'd0; step_abv = 4'd0; step_zro = 4'd0; step_sat = 4'd0;
    do_clear();
    for (int k = 0; k < 12; k++) send(((k * 12345) % 65536) - 32768, "R7");
    adj_max = 16'sd1; adj_min = -16'sd1;
    step_blw = 4'd15; step_abv = 4'd15; step_zro = 4'd15; step_sat = 4'd15;
    for (int k = 0; k < 12; k++) send((k % 3) * 200 + 5, "R7");
    adj_max = 16'sh7FFF; adj_min = -16'sh8000;
    step_blw = 4'd8; step_abv = 4'd9; step_zro = 4'd6; step_sat = 4'd6;
    for (int k = 0; k < 10; k++) send(((k * 2221) % 65536) - 32768, "R4");
    // R8 R11: freeze bit, then the hold input
    freeze = 1'b1;
    for (int k = 0; k < 10; k++) send(((k * 3331) % 65536) - 32768, "R11");
    freeze = 1'b0; hold_in = 1'b1;
    for (int k = 0; k < 10; k++) send(((k * 5557) % 65536) - 32768, "R8");
    // R9: clear while held leaves the base gain alone in effect
    do_clear();
    for (int k = 0; k < 6; k++) send(((k * 9001) % 65536) - 32768, "R9");
    hold_in = 1'b0;
    send(1000, "R9");
    do_clear();
    send(-1000, "R9");
    // R2: dual channels with distinct base gains
    if (m_ph != 0) send(77, "R2");
    dual_mode = 1'b1; base_gain_b = 24'h0C0000;
    for (int k = 0; k < 24; k++) send(((k * 6151) % 65536) - 32768, "R2");
    idle_check("R1");
    // R12: packed gain and state, dual then single
    gain_mon = 1'b1;
    for (int k = 0; k < 16; k++) send(((k * 7001) % 65536) - 32768, "R12");
    dual_mode = 1'b0;
    if (m_ph != 0) send(33, "R12");
    for (int k = 0; k < 16; k++) send(((k * 1777) % 65536) - 32768, "R12");
    freeze = 1'b1;
    for (int k = 0; k < 4; k++) send(k * 4000 - 8000, "R12");
    freeze = 1'b0; gain_mon = 1'b0;
    idle_check("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule